// File: doc/BRIEF.md
# Bus-Master ATA DMA Channel

This block is one channel of a bus-master DMA engine for a parallel ATA host port. Software fills a table of region descriptors in system memory, loads the table address into the channel, issues a command to the drive and then sets the start bit. The channel fetches descriptors one at a time. For each region it moves 16-bit words between a simple drive-side data handshake and a memory request port, in the direction software picked. When the final region is finished it raises a sticky interrupt flag and drops its active flag.

Software sees an 8-byte register window: a command byte at offset 0, a status byte at offset 2 and a 32-bit table pointer at offset 4. Writing 1 to the interrupt or error flag in the status byte clears it. Two status bits are plain read/write flags that record which of the two drives may use DMA, and the top status bit reports a strap pin that says the two channels cannot run DMA at the same time. A second channel is a second instance whose window an outside decoder places 8 bytes above the first.

Top module: `bmdma_chan`

## Requirements
- R1: After reset the command byte reads 0, the table pointer reads 0 and status bits 6..0 read 0. Status bit 7 follows `simplex_strap`.
- R2: A write at offset 0 sets start (bit 0) and direction (bit 3). A write at offset 4 loads the 32-bit table pointer. Both registers read back what was written, and unused command bits read 0.
- R3: In a status write (offset 2), a 1 in bit 1 clears the error flag and a 1 in bit 2 clears the interrupt flag. A 0 in either bit leaves that flag unchanged.
- R4: Status bits 5 and 6 are read/write. Status bit 7 ignores writes and always shows `simplex_strap`.
- R5: Descriptors are 8 bytes long and are read in order starting at the table pointer. The first dword holds the buffer address. Bits 15..0 of the second dword hold the byte count, and bit 31 of the second dword marks the final descriptor. Both dwords are read as 32-bit accesses with `mem_wide`=1.
- R6: With direction 1, each drive word taken on `drv_rdata` is written to memory as a halfword (`mem_we`=1, data on `mem_wdata`, ascending even addresses). With direction 0, each halfword read from memory (returned on `mem_rdata[15:0]`) is handed to the drive on `drv_wdata`, strobed by `drv_ack`.
- R7: When the final descriptor's last word is done, status bits 2..0 read 100b: interrupt set, not active, no error.
- R8: A transfer completes correctly whether `drv_req` is raised before the start bit is set or some time after it.
- R9: A byte count of 0 means 65536 bytes; such a region is still active after many words.
- R10: If the drive requests data after the table is finished while start is still set, the error flag is set, no `drv_ack` is given and the channel stays stopped.
- R11: An `mem_err` response sets the error flag and clears active, and leaves the interrupt flag unchanged.
- R12: Clearing start during a transfer stops the channel between words. Active clears, interrupt and error are unchanged, and no further `drv_ack` follows.
- R13: Bit 0 of a descriptor's buffer address and bit 0 of its byte count are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| simplex_strap | input | 1 | Value shown in status bit 7 |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset in the register window (0, 2 or 4) |
| bus_wdata | input | 32 | Register write data (byte registers use bits 7..0) |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| mem_req | output | 1 | Memory request, held until ack or error |
| mem_we | output | 1 | 1 = memory write |
| mem_wide | output | 1 | 1 = 32-bit access, 0 = halfword access |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Halfword write data |
| mem_rdata | input | 32 | Read data; halfword reads return data on bits 15..0 |
| mem_ack | input | 1 | Access done, one-cycle pulse |
| mem_err | input | 1 | Access failed, one-cycle pulse in place of ack |
| drv_req | input | 1 | Drive asks to move one word |
| drv_ack | output | 1 | One word moved in this cycle |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive |

## Verification
A two-region drive-to-memory transfer, with the drive request raised before start, shows that descriptors are walked in order and that the region switch loses no word. A memory-to-drive transfer with an odd address and an odd count, and with the request raised late, tells a correct bit-0 mask and late-request handling apart from an engine that stalls or shifts its data. Three further patterns each take one path out of the transfer: a drive that offers one word too many, a memory error on the second data word, and a zero-count region stopped by clearing start. Each of these leaves its own pattern in the low status bits and in the number of drive strobes.

// File: rtl/bmdma_chan.sv
module bmdma_chan (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        simplex_strap,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_wide,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic        drv_req,
  output logic        drv_ack,
  input  logic [15:0] drv_rdata,
  output logic [15:0] drv_wdata
);
  typedef enum logic [2:0] {S_IDLE, S_DF0, S_DF1, S_WAIT, S_MEM, S_PUT, S_DONE} st_t;

  st_t         st, st_after;
  logic        cmd_start, cmd_rd, st_err, st_int, fin;
  logic [1:0]  cap;
  logic [31:0] tbl_ptr, dp, buf_a;
  logic [16:0] cnt, cnt_ld;
  logic [15:0] dbuf;
  logic        active, wr_cmd, wr_sta, wr_ptr, go, last_word;
  logic [7:0]  status;
  logic        unused_bits;

  assign active    = (st != S_IDLE) && (st != S_DONE);
  assign wr_cmd    = bus_we && bus_addr == 3'd0;
  assign wr_sta    = bus_we && bus_addr == 3'd2;
  assign wr_ptr    = bus_we && bus_addr == 3'd4;
  assign go        = wr_cmd && bus_wdata[0] && !cmd_start && st == S_IDLE;
  assign last_word = cnt == 17'd2;
  assign cnt_ld    = (mem_rdata[15:1] == 15'd0) ? 17'h10000 : {1'b0, mem_rdata[15:1], 1'b0};
  assign status    = {simplex_strap, cap, 2'b00, st_int, st_err, active};
  assign unused_bits = ^{mem_rdata[0], tbl_ptr[1:0]};

  assign mem_req   = st == S_DF0 || st == S_DF1 || st == S_MEM;
  assign mem_wide  = st != S_MEM;
  assign mem_we    = st == S_MEM && cmd_rd;
  assign mem_addr  = (st == S_MEM) ? buf_a : dp;
  assign mem_wdata = dbuf;
  assign drv_ack   = st == S_PUT || (st == S_WAIT && cmd_start && drv_req && cmd_rd);
  assign drv_wdata = dbuf;

  always_comb begin
    if (last_word && fin)  st_after = S_DONE;
    else if (!cmd_start)   st_after = S_IDLE;
    else if (last_word)    st_after = S_DF0;
    else                   st_after = S_WAIT;
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {28'd0, cmd_rd, 2'b00, cmd_start};
      3'd2:    bus_rdata = {24'd0, status};
      3'd4:    bus_rdata = tbl_ptr;
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cmd_start <= 1'b0; cmd_rd <= 1'b0;
      st_err <= 1'b0; st_int <= 1'b0; cap <= 2'b00; fin <= 1'b0;
      tbl_ptr <= '0; dp <= '0; buf_a <= '0; cnt <= '0; dbuf <= '0;
    end else begin
      if (wr_cmd) begin
        cmd_start <= bus_wdata[0];
        cmd_rd    <= bus_wdata[3];
      end
      if (wr_ptr) tbl_ptr <= bus_wdata;
      if (wr_sta) begin
        cap <= bus_wdata[6:5];
        if (bus_wdata[1]) st_err <= 1'b0;
        if (bus_wdata[2]) st_int <= 1'b0;
      end
      case (st)
        S_IDLE: if (go) begin
          dp <= {tbl_ptr[31:2], 2'b00};
          st <= S_DF0;
        end
        S_DF0:
          if (mem_err) begin st_err <= 1'b1; st <= S_IDLE; end
          else if (mem_ack) begin
            buf_a <= {mem_rdata[31:1], 1'b0};
            dp    <= dp + 32'd4;
            st    <= S_DF1;
          end
        S_DF1:
          if (mem_err) begin st_err <= 1'b1; st <= S_IDLE; end
          else if (mem_ack) begin
            cnt <= cnt_ld;
            fin <= mem_rdata[31];
            dp  <= dp + 32'd4;
            st  <= cmd_start ? S_WAIT : S_IDLE;
          end
        S_WAIT:
          if (!cmd_start) st <= S_IDLE;
          else if (drv_req) begin
            if (cmd_rd) dbuf <= drv_rdata;
            st <= S_MEM;
          end
        S_MEM:
          if (mem_err) begin st_err <= 1'b1; st <= S_IDLE; end
          else if (mem_ack) begin
            if (cmd_rd) begin
              buf_a <= buf_a + 32'd2;
              cnt   <= cnt - 17'd2;
              st    <= st_after;
              if (st_after == S_DONE) st_int <= 1'b1;
            end else begin
              dbuf <= mem_rdata[15:0];
              st   <= S_PUT;
            end
          end
        S_PUT: begin
          buf_a <= buf_a + 32'd2;
          cnt   <= cnt - 17'd2;
          st    <= st_after;
          if (st_after == S_DONE) st_int <= 1'b1;
        end
        S_DONE:
          if (!cmd_start) st <= S_IDLE;
          else if (drv_req) begin st_err <= 1'b1; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bmdma_chan_chk.sv
module bmdma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        cmd_start,
  input logic        st_int,
  input logic        st_err,
  input logic        drv_ack,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_addr,
  input logic        bus_we,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata
);
  a_r3_w1c_int: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2 && bus_wdata[2] && !active) |=> !st_int);

  a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> (mem_req && $stable(mem_addr)));

  a_r7_int_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_int) |-> !active);

  a_r10_ack_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    drv_ack |-> active);

  a_r11_mem_err_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_err) |=> (!active && st_err));

  a_r12_abort_between_words: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !cmd_start && !mem_req) |=> !active);
endmodule

bind bmdma_chan bmdma_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .active(active), .cmd_start(cmd_start),
  .st_int(st_int), .st_err(st_err), .drv_ack(drv_ack), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_err(mem_err), .mem_addr(mem_addr),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/bmdma_chan_tb.sv
`timescale 1ns/1ps
module bmdma_chan_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        mem_req, mem_we, mem_wide;
  logic [31:0] mem_addr, mem_rdata;
  logic [15:0] mem_wdata;
  logic        mem_ack, mem_err;
  logic        drv_req, drv_ack;
  logic [15:0] drv_rdata, drv_wdata;

  bmdma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .simplex_strap(1'b1),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .drv_req(drv_req), .drv_ack(drv_ack), .drv_rdata(drv_rdata), .drv_wdata(drv_wdata)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [31:0] mem [0:255];
  logic        inj = 1'b0;
  logic [31:0] inj_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0;
    end else if (mem_req && !mem_ack && !mem_err) begin
      if (inj && mem_addr == inj_addr) mem_err <= 1'b1;
      else begin
        mem_ack <= 1'b1;
        if (mem_wide) mem_rdata <= mem[mem_addr[9:2]];
        else mem_rdata <= {16'd0, mem_addr[1] ? mem[mem_addr[9:2]][31:16] : mem[mem_addr[9:2]][15:0]};
      end
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
    if (mem_ack && mem_we) begin
      if (mem_addr[1]) mem[mem_addr[9:2]][31:16] <= mem_wdata;
      else mem[mem_addr[9:2]][15:0] <= mem_wdata;
    end
  end

  logic drv_on = 1'b0, drv_clr = 1'b0;
  int   drv_lim = 0, drv_idx = 0;
  logic [15:0] sink [0:63];
  assign drv_req   = drv_on && (drv_idx < drv_lim);
  assign drv_rdata = 16'hA000 + drv_idx[15:0];
  always @(posedge clk) begin
    if (drv_clr) drv_idx <= 0;
    else if (drv_ack) begin
      sink[drv_idx % 64] <= drv_wdata;
      drv_idx <= drv_idx + 1;
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #0.5; d = bus_rdata;
  endtask

  function automatic logic [15:0] half(input logic [31:0] a);
    return a[1] ? mem[a[9:2]][31:16] : mem[a[9:2]][15:0];
  endfunction

  task automatic put_half(input logic [31:0] a, input logic [15:0] v);
    if (a[1]) mem[a[9:2]][31:16] = v; else mem[a[9:2]][15:0] = v;
  endtask

  task automatic drv_reset(input bit on, input int lim);
    @(negedge clk); drv_clr = 1'b1;
    @(negedge clk); drv_clr = 1'b0; drv_on = on; drv_lim = lim;
  endtask

  task automatic wait_stop();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd2, s);
      if (!s[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic clean();
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h06);
    drv_reset(1'b0, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); check(v == 32'h0, "R1 cmd", v, 32'h0);
    rd(3'd2, v); check(v == 32'h80, "R1 status", v, 32'h80);
    rd(3'd4, v); check(v == 32'h0, "R1 ptr", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, v); check(v == 32'h1234_5678, "R2 ptr", v, 32'h1234_5678);
    wr(3'd0, 32'hF8);
    rd(3'd0, v); check(v == 32'h08, "R2 cmd", v, 32'h08);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h60);
    rd(3'd2, v); check(v == 32'hE0, "R4 caps set", v, 32'hE0);
    wr(3'd2, 32'h00);
    rd(3'd2, v); check(v == 32'h80, "R4 simplex read-only", v, 32'h80);
  endtask

  task automatic t_read_xfer();
    logic [31:0] v;
    mem[64] = 32'h0000_0200; mem[65] = 32'h0000_0006;
    mem[66] = 32'h0000_0300; mem[67] = 32'h8000_0004;
    wr(3'd4, 32'h100);
    drv_reset(1'b1, 5);
    wr(3'd0, 32'h09);
    wait_stop();
    rd(3'd2, v); check(v[2:0] == 3'b100, "R7 R8 good status", v, 32'h4);
    check(drv_idx == 5, "R5 word count", drv_idx, 5);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] a;
      a = (i < 3) ? 32'h200 + 2 * i : 32'h300 + 2 * (i - 3);
      check(half(a) == 16'hA000 + i[15:0], "R6 drive-to-memory data", half(a), 16'hA000 + i[15:0]);
    end
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(3'd2, 32'h02);
    rd(3'd2, v); check(v[2] == 1'b1, "R3 int kept on 0", v, 32'h84);
    wr(3'd2, 32'h04);
    rd(3'd2, v); check(v[2:0] == 3'b000, "R3 int cleared", v, 32'h80);
    wr(3'd0, 32'h0);
  endtask

  task automatic t_write_xfer();
    logic [31:0] v;
    for (int i = 0; i < 4; i++) put_half(32'h240 + 2 * i, 16'hB000 + i[15:0]);
    mem[80] = 32'h0000_0241; mem[81] = 32'h8000_0005;
    wr(3'd4, 32'h140);
    drv_reset(1'b0, 2);
    wr(3'd0, 32'h01);
    repeat (12) @(negedge clk);
    drv_on = 1'b1;
    wait_stop();
    rd(3'd2, v); check(v[2:0] == 3'b100, "R8 R13 late request status", v, 32'h4);
    check(drv_idx == 2, "R13 masked count", drv_idx, 2);
    check(sink[0] == 16'hB000, "R6 R13 word0", sink[0], 16'hB000);
    check(sink[1] == 16'hB001, "R6 word1", sink[1], 16'hB001);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    mem[96] = 32'h0000_0280; mem[97] = 32'h8000_0004;
    wr(3'd4, 32'h180);
    drv_reset(1'b1, 3);
    wr(3'd0, 32'h09);
    wait_stop();
    rd(3'd2, v); check(v[2:0] == 3'b110, "R10 overrun status", v, 32'h6);
    check(drv_idx == 2, "R10 no extra ack", drv_idx, 2);
  endtask

  task automatic t_memerr();
    logic [31:0] v;
    mem[112] = 32'h0000_02C0; mem[113] = 32'h8000_0008;
    wr(3'd4, 32'h1C0);
    inj = 1'b1; inj_addr = 32'h2C2;
    drv_reset(1'b1, 4);
    wr(3'd0, 32'h09);
    wait_stop();
    inj = 1'b0;
    rd(3'd2, v); check(v[2:0] == 3'b010, "R11 memory error status", v, 32'h2);
    check(drv_idx == 2, "R11 stopped after error", drv_idx, 2);
  endtask

  task automatic t_zero_abort();
    logic [31:0] v;
    int held;
    mem[120] = 32'h0000_0400; mem[121] = 32'h8000_0000;
    wr(3'd4, 32'h1E0);
    drv_reset(1'b1, 40);
    wr(3'd0, 32'h09);
    for (int i = 0; i < 2000 && drv_idx < 40; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    rd(3'd2, v); check(v[2:0] == 3'b001, "R9 zero count still active", v, 32'h1);
    wr(3'd0, 32'h08);
    repeat (4) @(negedge clk);
    rd(3'd2, v); check(v[2:0] == 3'b000, "R12 abort status", v, 32'h0);
    held = drv_idx;
    drv_lim = 1000;
    repeat (20) @(negedge clk);
    check(drv_idx == held, "R12 no strobes after abort", drv_idx, held);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_read_xfer();
    t_w1c();
    clean();
    t_write_xfer();
    clean();
    t_overrun();
    clean();
    t_memerr();
    clean();
    t_zero_abort();
    clean();
    report();
  end
endmodule